// File: doc/BRIEF.md
# Dual Programmable PLL Frequency Dividers

This block contains the two divider chains that feed a frequency synthesizer's phase detector. The feedback path divides the VCO feedback clock by a 16-bit ratio, with a floor of 1056. The reference path first divides the reference clock by a fixed factor of four. It then divides by a programmable count, so its overall ratio moves in steps of four and never drops below 20.

Each path emits a pulse one input-clock cycle wide, once per full division period. The same pulse is the buffered divider output and the phase-detector input. The ratio inputs come from holding registers loaded by a separate serial interface. A divider samples its ratio only at its own terminal count, so a new value shapes the next full period and never shortens the one in progress. A parameter selects a 14-bit reference count (the default) or an 11-bit one.

Top module: `pll_dual_divider`

## Requirements
- R1: `fb_div_out` pulses once every N cycles of `fb_clk`, where N is the value on `n_ratio` (for N of 1056 or more).
- R2: An `n_ratio` value below 1056 is treated as 1056.
- R3: `ref_div_out` pulses once every 4*R cycles of `ref_clk`, where R is the value on `r_ratio` (for R of 5 or more).
- R4: An `r_ratio` value below 5 (including 0) is treated as 5, giving a reference period of 20 cycles.
- R5: Each pulse on `fb_div_out` and on `ref_div_out` is high for exactly one cycle of its own clock.
- R6: A ratio changed partway through a division period does not alter that period; the new value sets the length of the following period.
- R7: A ratio change presented in the same cycle as the terminal count is used for the period that starts at that terminal count.
- R8: While `rst_n` is low, both outputs are low.
- R9: With the default `R_WIDE`=1 the reference count is 14 bits wide, and its upper bits take part in the ratio (R=4100, with bit 12 set, gives a 16400-cycle period). With `R_WIDE`=0 it is 11 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fb_clk | input | 1 | Feedback (VCO) clock to be divided |
| ref_clk | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset for both paths |
| n_ratio | input | 16 | Feedback division ratio from its holding register |
| r_ratio | input | 14 (11 if R_WIDE=0) | Reference count (overall ratio is four times this) |
| fb_div_out | output | 1 | One-cycle pulse per feedback division period |
| ref_div_out | output | 1 | One-cycle pulse per reference division period |

## Verification
Two events can fall on the same clock edge. One is the terminal count, which reloads the counter. The other is a write of a new ratio into the holding register. The bench measures one period and then waits one cycle less than that period. It changes `n_ratio` exactly on the edge that produces the next pulse, and then expects that pulse to arrive on time and the period that follows to take the new value. A separate case changes the ratio in the middle of a period and checks that the running period keeps its old length.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam int N_BITS  = 16;
  localparam int N_FLOOR = 1056;
  localparam int R_FLOOR = 5;
  localparam int PRE_DIV = 4;

  // Raise a requested ratio to a lower bound; arithmetic kept here so the
  // bench can restate it independently.
  function automatic logic [15:0] floor_ratio(input logic [15:0] req,
                                              input logic [15:0] lo);
    return (req < lo) ? lo : req;
  endfunction
endpackage

// File: rtl/presc_div4.sv
module presc_div4 #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe
);
  localparam int PB = $clog2(DIV);
  localparam logic [PB-1:0] LAST = PB'(DIV - 1);

  logic [PB-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  assign strobe = (phase == LAST);

  // R3: enable strobe is never high on two consecutive cycles
  p_strobe_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/prog_counter.sv
module prog_counter
  import pll_div_pkg::*;
#(
  parameter int W   = 16,
  parameter int MIN = 1056
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] ratio,
  output logic         tc,
  output logic         pulse
);
  localparam logic [W-1:0] LOAD_MIN = W'(MIN - 1);

  logic [W-1:0] cnt;
  logic [W-1:0] eff_ratio;

  assign eff_ratio = W'(floor_ratio(16'(ratio), 16'(MIN)));
  assign tc        = en && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= tc;
      if (tc)      cnt <= eff_ratio - 1'b1;
      else if (en) cnt <= cnt - 1'b1;
    end
  end

  // R5: output pulse lasts one cycle
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  // R4 (and R2): a reload never sets a period shorter than the floor
  p_reload_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> (cnt >= LOAD_MIN));
  // R3: count holds between prescaler strobes
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
endmodule

// File: rtl/pll_dual_divider.sv
module pll_dual_divider
  import pll_div_pkg::*;
#(
  parameter int R_WIDE = 1
) (
  input  logic                         fb_clk,
  input  logic                         ref_clk,
  input  logic                         rst_n,
  input  logic [15:0]                  n_ratio,
  input  logic [(R_WIDE ? 14 : 11)-1:0] r_ratio,
  output logic                         fb_div_out,
  output logic                         ref_div_out
);
  localparam int RW = R_WIDE ? 14 : 11;

  logic fb_tc;
  logic ref_tc;
  logic presc_strobe;

  prog_counter #(.W(N_BITS), .MIN(N_FLOOR)) u_fb_cnt (
    .clk(fb_clk), .rst_n(rst_n), .en(1'b1), .ratio(n_ratio),
    .tc(fb_tc), .pulse(fb_div_out)
  );

  presc_div4 #(.DIV(PRE_DIV)) u_presc (
    .clk(ref_clk), .rst_n(rst_n), .strobe(presc_strobe)
  );

  prog_counter #(.W(RW), .MIN(R_FLOOR)) u_ref_cnt (
    .clk(ref_clk), .rst_n(rst_n), .en(presc_strobe), .ratio(r_ratio),
    .tc(ref_tc), .pulse(ref_div_out)
  );

  // R3: a reference pulse only follows a prescaler strobe edge
  p_ref_after_strobe_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_div_out |-> $past(presc_strobe));
  // R1: feedback terminal count always yields a pulse on the next edge
  p_fb_tc_pulse_r1: assert property (@(posedge fb_clk) disable iff (!rst_n)
    fb_tc |=> $rose(fb_div_out));
  // R3: reference terminal count only on an enabled cycle
  p_ref_tc_enabled_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_tc |-> presc_strobe);
endmodule

// File: tb/pll_dual_divider_tb_top.sv
module pll_dual_divider_tb_top;
  logic fb_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] n_ratio = 16'd1056;
  logic [13:0] r_ratio = 14'd5;
  logic fb_div_out, ref_div_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 fb_clk = ~fb_clk;
  always #5 ref_clk = ~ref_clk;

  pll_dual_divider #(.R_WIDE(1)) dut_i (
    .fb_clk(fb_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .n_ratio(n_ratio), .r_ratio(r_ratio),
    .fb_div_out(fb_div_out), .ref_div_out(ref_div_out)
  );

  // Vectors: n in, r in, expected fb period, expected ref period
  localparam int NV = 6;
  localparam int VEC[NV][4] = '{
    '{100,  2,   1056, 20},
    '{1056, 5,   1056, 20},
    '{1057, 6,   1057, 24},
    '{3000, 0,   3000, 20},
    '{1500, 300, 1500, 1200},
    '{1100, 4100, 1100, 16400}
  };

  function automatic int exp_fb(input int n);
    return (n < 1056) ? 1056 : n;
  endfunction
  function automatic int exp_ref(input int r);
    return 4 * ((r < 5) ? 5 : r);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input bit sel);
    return sel ? ref_div_out : fb_div_out;
  endfunction

  task automatic wait_pulse(input bit sel);
    do @(negedge fb_clk); while (sig(sel) !== 1'b1);
  endtask

  task automatic measure(input bit sel, output int per, output bit wide);
    per = 0;
    wide = 1'b0;
    forever begin
      @(negedge fb_clk);
      per++;
      if (sig(sel) === 1'b1) begin
        if (per == 1) wide = 1'b1;
        else break;
      end
    end
  endtask

  always @(negedge fb_clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int per;
    bit wide;
    // R8: outputs low during reset
    repeat (6) @(negedge fb_clk);
    check("R8 fb low in reset", int'(fb_div_out), 0);
    check("R8 ref low in reset", int'(ref_div_out), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      n_ratio = 16'(VEC[i][0]);
      r_ratio = 14'(VEC[i][1]);
      check("R2 bench model", exp_fb(VEC[i][0]), VEC[i][2]);
      wait_pulse(1'b0); wait_pulse(1'b0);
      measure(1'b0, per, wide);
      check(i == 0 ? "R2 fb clamp period" : "R1 fb period", per, VEC[i][2]);
      check("R5 fb width", int'(wide), 0);
      wait_pulse(1'b1); wait_pulse(1'b1);
      measure(1'b1, per, wide);
      check(VEC[i][1] < 5 ? "R4 ref clamp period" :
            (i == 5 ? "R9 ref upper bits" : "R3 ref period"),
            per, exp_ref(VEC[i][1]));
      check("R5 ref width", int'(wide), 0);
    end

    // R6: change mid-period; running period keeps old length
    n_ratio = 16'd2000;
    wait_pulse(1'b0); wait_pulse(1'b0);
    repeat (500) @(negedge fb_clk);
    n_ratio = 16'd1100;
    per = 500;
    do begin @(negedge fb_clk); per++; end while (fb_div_out !== 1'b1);
    check("R6 running period kept", per, 2000);
    measure(1'b0, per, wide);
    check("R6 next period new", per, 1100);

    // R7: change on the terminal-count edge itself
    n_ratio = 16'd1300;
    wait_pulse(1'b0); wait_pulse(1'b0);
    repeat (1299) @(negedge fb_clk);
    n_ratio = 16'd1700;
    per = 1299;
    do begin @(negedge fb_clk); per++; end while (fb_div_out !== 1'b1);
    check("R7 period at change", per, 1300);
    measure(1'b0, per, wide);
    check("R7 period after change", per, 1700);

    // R8: reset mid-run forces outputs low
    rst_n = 1'b0;
    repeat (3) @(negedge fb_clk);
    check("R8 fb low after reset", int'(fb_div_out), 0);
    check("R8 ref low after reset", int'(ref_div_out), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule